// File: doc/BRIEF.md
# Transition-Limiting Bus Inversion Codec

This block encodes a group of byte-wide lanes on the write side of a bidirectional data bus and decodes them on the read side. Each lane carries eight data wires and one inversion wire. On every accepted write beat the encoder compares the new byte with what that lane drove last, data wires and inversion wire together. If the plain byte would switch too many wires, the encoder sends its complement and raises the inversion wire instead. This keeps simultaneous switching low on every lane.

The last driven value of each lane is the reference for the next beat. It belongs to the lane and not to a transfer, so a two-beat access is encoded beat by beat. The first beat of the next access is compared with the final beat of the one before, however long the bus sat idle between them. The read-side decoder restores each received byte by complementing it when its inversion wire is high. A parameter selects whether the decoder output is registered or combinational. Lane count and lane width are parameters.

Top module: `tdbi_lane_codec`

## Requirements
- R1: Each lane of LANE_W (default 8) data bits has exactly one inversion bit; lane k occupies data bits [k*LANE_W +: LANE_W] and inversion bit k on both paths.
- R2: On an accepted write beat, when sending the plain byte with the inversion bit low would switch more than LANE_W/2 of the lane's LANE_W+1 wires relative to the last driven lane value, the encoder drives the complemented byte with the inversion bit high.
- R3: When the plain byte would switch at most LANE_W/2 wires, including the case of exactly LANE_W/2, the plain byte is driven with the inversion bit low.
- R4: Between two consecutive driven values, at most LANE_W/2 of a lane's LANE_W+1 wires change.
- R5: The encoded beat appears on tx_q_data/tx_q_inv one clock after tx_valid is sampled high, and tx_q_valid is high in exactly that cycle.
- R6: While tx_valid is low, the encoder outputs hold and the lane reference does not change, so the next beat is encoded against the last driven value.
- R7: The lane reference persists across idle gaps between bursts and is not cleared at burst boundaries. Within a two-beat burst, the second beat is encoded against the first.
- R8: Reset clears every lane's reference and outputs to all-zero data with the inversion bit low; nothing else clears them.
- R9: The decoder outputs each received byte complemented when its inversion bit is high and unchanged when it is low. With DEC_REG=1 the result appears one clock after rx_valid is sampled high, together with rx_q_valid.
- R10: With DEC_REG=1, while rx_valid is low the decoder outputs hold.
- R11: Lanes are encoded independently: the decision on one lane does not depend on the data of any other lane.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Write beat present on tx_data |
| tx_data | input | LANES*LANE_W | Unencoded write beat |
| tx_q_valid | output | 1 | Encoded beat updated this cycle |
| tx_q_data | output | LANES*LANE_W | Encoded lane data driven to the bus |
| tx_q_inv | output | LANES | Inversion bit per lane |
| rx_valid | input | 1 | Read beat present on rx_data |
| rx_data | input | LANES*LANE_W | Received encoded data |
| rx_inv | input | LANES | Received inversion bit per lane |
| rx_q_valid | output | 1 | Decoded beat valid |
| rx_q_data | output | LANES*LANE_W | Decoded read data |

## Verification
The write encoder and the read decoder share no state, so a write beat and a read beat can arrive in the same clock. The bench provokes this by feeding the encoder's previous output back into the decoder while the encoder accepts its next beat. It then judges both results in the following cycle: the encoded beat against a bench model of the transition rule, and the decoded byte against the original plain byte. A second overlap happens inside a single beat, where some lanes take the inversion path and others do not. The bench builds beats that mix lanes exactly at the switching threshold with lanes just above it, and checks each lane's inversion bit on its own.

// File: rtl/tdbi_pkg.sv
package tdbi_pkg;

   // number of set bits in a word of up to 64 bits
   function automatic int unsigned ones_in(input logic [63:0] v, input int unsigned n);
      int unsigned c;
      c = 0;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i < n && v[i]) c++;
      end
      return c;
   endfunction

endpackage

// File: rtl/tdbi_lane_enc.sv
module tdbi_lane_enc
   import tdbi_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         beat_ok,
   input  logic [W-1:0] plain,
   output logic [W-1:0] wire_data,
   output logic         wire_inv
);
   localparam int unsigned LIMIT = W / 2;

   logic [W-1:0] last_data;
   logic         last_inv;
   logic [W-1:0] delta;
   int unsigned  plain_sw;
   logic         flip;

   always_comb begin
      delta    = plain ^ last_data;
      plain_sw = ones_in(64'(delta), W) + (last_inv ? 1 : 0);
      flip     = (plain_sw > LIMIT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_data <= '0;
         last_inv  <= 1'b0;
      end else if (beat_ok) begin
         last_data <= flip ? ~plain : plain;
         last_inv  <= flip;
      end
   end

   assign wire_data = last_data;
   assign wire_inv  = last_inv;
endmodule

// File: rtl/tdbi_lane_dec.sv
module tdbi_lane_dec #(
   parameter int unsigned W       = 8,
   parameter bit          DEC_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         beat_ok,
   input  logic [W-1:0] coded,
   input  logic         inv,
   output logic [W-1:0] plain
);
   logic [W-1:0] restored;

   assign restored = coded ^ {W{inv}};

   generate
      if (DEC_REG) begin : g_reg
         logic [W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hold_q <= '0;
            else if (beat_ok) hold_q <= restored;
         end
         assign plain = hold_q;
      end else begin : g_comb
         assign plain = restored;
      end
   endgenerate
endmodule

// File: rtl/tdbi_lane_codec.sv
module tdbi_lane_codec #(
   parameter int unsigned LANES   = 4,
   parameter int unsigned LANE_W  = 8,
   parameter bit          DEC_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tx_valid,
   input  logic [LANES*LANE_W-1:0]  tx_data,
   output logic                     tx_q_valid,
   output logic [LANES*LANE_W-1:0]  tx_q_data,
   output logic [LANES-1:0]         tx_q_inv,
   input  logic                     rx_valid,
   input  logic [LANES*LANE_W-1:0]  rx_data,
   input  logic [LANES-1:0]         rx_inv,
   output logic                     rx_q_valid,
   output logic [LANES*LANE_W-1:0]  rx_q_data
);
   localparam int unsigned BUS_W = LANES * LANE_W;

   if (LANES < 1) begin : g_bad_lanes
      initial $fatal(1, "LANES must be at least 1");
   end
   if (LANE_W < 2 || LANE_W > 64 || (LANE_W % 2) != 0) begin : g_bad_width
      initial $fatal(1, "LANE_W must be even and within 2..64");
   end
   if (BUS_W < LANE_W) begin : g_bad_bus
      initial $fatal(1, "bus width inconsistent");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_q_valid <= 1'b0;
      else        tx_q_valid <= tx_valid;
   end

   generate
      if (DEC_REG) begin : g_rxv_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rx_q_valid <= 1'b0;
            else        rx_q_valid <= rx_valid;
         end
      end else begin : g_rxv_comb
         assign rx_q_valid = rx_valid;
      end
   endgenerate

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      tdbi_lane_enc #(.W(LANE_W)) enc_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .beat_ok   (tx_valid),
         .plain     (tx_data[k*LANE_W +: LANE_W]),
         .wire_data (tx_q_data[k*LANE_W +: LANE_W]),
         .wire_inv  (tx_q_inv[k])
      );
      tdbi_lane_dec #(.W(LANE_W), .DEC_REG(DEC_REG)) dec_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .beat_ok (rx_valid),
         .coded   (rx_data[k*LANE_W +: LANE_W]),
         .inv     (rx_inv[k]),
         .plain   (rx_q_data[k*LANE_W +: LANE_W])
      );
   end
endmodule

// File: rtl/tdbi_lane_codec_chk.sv
module tdbi_lane_codec_chk #(
   parameter int unsigned LANES   = 4,
   parameter int unsigned LANE_W  = 8,
   parameter bit          DEC_REG = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     tx_valid,
   input logic [LANES*LANE_W-1:0]  tx_data,
   input logic                     tx_q_valid,
   input logic [LANES*LANE_W-1:0]  tx_q_data,
   input logic [LANES-1:0]         tx_q_inv,
   input logic                     rx_valid,
   input logic [LANES*LANE_W-1:0]  rx_data,
   input logic [LANES-1:0]         rx_inv,
   input logic                     rx_q_valid,
   input logic [LANES*LANE_W-1:0]  rx_q_data
);
   localparam int unsigned LIMIT = LANE_W / 2;

   logic ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ok <= 1'b0;
      else        ok <= 1'b1;
   end

   // R5: output valid trails the input strobe by one clock
   a_r5_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> (tx_q_valid == $past(tx_valid)));

   // R6: idle input leaves the driven lanes untouched
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ok && !tx_q_valid) |-> ($stable(tx_q_data) && $stable(tx_q_inv)));

   for (genvar k = 0; k < LANES; k++) begin : g_l
      // R4: switching budget per lane
      a_r4_toggle_cap: assert property (@(posedge clk) disable iff (!rst_n)
         (ok && tx_q_valid) |->
            ($countones({tx_q_data[k*LANE_W +: LANE_W], tx_q_inv[k]} ^
                        {$past(tx_q_data[k*LANE_W +: LANE_W]), $past(tx_q_inv[k])}) <= LIMIT));

      // R2: inversion only when the plain byte would exceed the budget
      a_r2_inv_justified: assert property (@(posedge clk) disable iff (!rst_n)
         (ok && tx_q_valid && tx_q_inv[k]) |->
            (($countones((~tx_q_data[k*LANE_W +: LANE_W]) ^ $past(tx_q_data[k*LANE_W +: LANE_W]))
              + ($past(tx_q_inv[k]) ? 1 : 0)) > LIMIT));

      if (DEC_REG) begin : g_dr
         // R9: registered decode of the sampled beat
         a_r9_decode: assert property (@(posedge clk) disable iff (!rst_n)
            (ok && rx_q_valid) |->
               (rx_q_data[k*LANE_W +: LANE_W] ==
                ($past(rx_data[k*LANE_W +: LANE_W]) ^ {LANE_W{$past(rx_inv[k])}})));
         // R10: decoder holds while idle
         a_r10_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (ok && !rx_q_valid) |-> $stable(rx_q_data[k*LANE_W +: LANE_W]));
      end
   end
endmodule

bind tdbi_lane_codec tdbi_lane_codec_chk #(
   .LANES(LANES), .LANE_W(LANE_W), .DEC_REG(DEC_REG)
) chk_i (.*);

// File: tb/tdbi_lane_codec_tb.sv
module tdbi_lane_codec_tb_top;
   localparam int unsigned LANES = 4;
   localparam int unsigned LW    = 8;
   localparam int unsigned BW    = LANES * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_valid = 1'b0;
   logic [BW-1:0] tx_data = '0;
   logic          tx_q_valid;
   logic [BW-1:0] tx_q_data;
   logic [LANES-1:0] tx_q_inv;
   logic          rx_valid = 1'b0;
   logic [BW-1:0] rx_data = '0;
   logic [LANES-1:0] rx_inv = '0;
   logic          rx_q_valid;
   logic [BW-1:0] rx_q_data;

   int n_chk = 0;
   int n_bad = 0;

   logic [LW-1:0] m_data [LANES];
   logic          m_inv  [LANES];
   logic [31:0]   lfsr = 32'hACE1_1234;

   always #4 clk = ~clk;

   tdbi_lane_codec #(.LANES(LANES), .LANE_W(LW), .DEC_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_q_valid(tx_q_valid), .tx_q_data(tx_q_data), .tx_q_inv(tx_q_inv),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_inv(rx_inv),
      .rx_q_valid(rx_q_valid), .rx_q_data(rx_q_data)
   );

   task automatic check(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int sw(input logic [LW-1:0] a, input logic [LW-1:0] b);
      int c = 0;
      for (int i = 0; i < LW; i++) if (a[i] != b[i]) c++;
      return c;
   endfunction

   function automatic logic [31:0] rnd();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < LANES; k++) begin m_data[k] = '0; m_inv[k] = 1'b0; end
   endtask

   // drive one beat and check it one clock later; leaves tx_valid high
   task automatic send(input logic [BW-1:0] d, input string req);
      logic [BW-1:0] e_d;
      logic [LANES-1:0] e_i;
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      for (int k = 0; k < LANES; k++) begin
         logic [LW-1:0] b;
         int p;
         b = d[k*LW +: LW];
         p = sw(b, m_data[k]) + (m_inv[k] ? 1 : 0);
         if (p > LW/2) begin e_d[k*LW +: LW] = ~b; e_i[k] = 1'b1; end
         else          begin e_d[k*LW +: LW] = b;  e_i[k] = 1'b0; end
      end
      @(negedge clk);
      check(tx_q_valid === 1'b1, "R5", 64'(tx_q_valid), 64'd1);
      check(tx_q_data === e_d && tx_q_inv === e_i, req,
            {28'd0, tx_q_inv, tx_q_data}, {28'd0, e_i, e_d});
      for (int k = 0; k < LANES; k++) begin
         int t;
         t = sw(tx_q_data[k*LW +: LW], m_data[k]) + ((tx_q_inv[k] != m_inv[k]) ? 1 : 0);
         check(t <= LW/2, "R4", 64'(t), 64'(LW/2));
         m_data[k] = e_d[k*LW +: LW];
         m_inv[k]  = e_i[k];
      end
   endtask

   // idle cycles with changing junk on tx_data
   task automatic idle(input int n);
      logic [BW-1:0] hd;
      logic [LANES-1:0] hi;
      tx_valid = 1'b0;
      @(negedge clk);
      hd = tx_q_data; hi = tx_q_inv;
      for (int i = 0; i < n; i++) begin
         tx_data = rnd();
         @(negedge clk);
         check(tx_q_valid === 1'b0 && tx_q_data === hd && tx_q_inv === hi, "R6",
               {27'd0, tx_q_valid, tx_q_inv, tx_q_data}, {28'd0, hi, hd});
      end
   endtask

   task automatic t_reset();
      tx_valid = 1'b0; rx_valid = 1'b0;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check(tx_q_data === '0 && tx_q_inv === '0 && tx_q_valid === 1'b0, "R8",
            {27'd0, tx_q_valid, tx_q_inv, tx_q_data}, 64'd0);
      check(rx_q_valid === 1'b0 && rx_q_data === '0, "R8", 64'(rx_q_data), 64'd0);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic t_threshold();
      // lane0: 4 wires switch -> plain; lane1: 5 switch -> inverted; R1 lane mapping
      send(32'h0000_1F0F, "R3");
      check(tx_q_data[7:0] === 8'h0F && tx_q_inv[0] === 1'b0, "R3",
            {55'd0, tx_q_inv[0], tx_q_data[7:0]}, 64'h00F);
      check(tx_q_data[15:8] === 8'hE0 && tx_q_inv[1] === 1'b1, "R2",
            {55'd0, tx_q_inv[1], tx_q_data[15:8]}, 64'h1E0);
      check(tx_q_data[31:16] === 16'h0000 && tx_q_inv[3:2] === 2'b00, "R11",
            {46'd0, tx_q_inv[3:2], tx_q_data[31:16]}, 64'd0);
      // lane1 reference now E0 with inversion high: the inversion wire counts
      send(32'h0000_1F0F, "R2");
      check(tx_q_data[15:8] === 8'hE0 && tx_q_inv[1] === 1'b1, "R2",
            {55'd0, tx_q_inv[1], tx_q_data[15:8]}, 64'h1E0);
      send(32'h0000_F00F, "R3");
      check(tx_q_data[15:8] === 8'hF0 && tx_q_inv[1] === 1'b0, "R3",
            {55'd0, tx_q_inv[1], tx_q_data[15:8]}, 64'h0F0);
      idle(2);
   endtask

   task automatic t_persist();
      // two-beat bursts separated by idle gaps; reference carries over
      send(32'hFFFF_FFFF, "R7");
      send(32'h0F0F_3C3C, "R7");
      idle(5);
      send(32'hF0F0_C3C3, "R7");
      send(32'h1234_5678, "R7");
      idle(3);
   endtask

   task automatic t_stream();
      for (int i = 0; i < 40; i++) begin
         send(rnd(), "R2");
         if (i % 7 == 6) idle(1);
      end
      idle(1);
   endtask

   task automatic t_decode();
      logic [BW-1:0] p;
      for (int i = 0; i < 12; i++) begin
         p = rnd();
         @(negedge clk);
         rx_valid = 1'b1;
         rx_data  = p;
         rx_inv   = LANES'(i);
         @(negedge clk);
         for (int k = 0; k < LANES; k++) begin
            logic [LW-1:0] e;
            e = rx_inv[k] ? ~p[k*LW +: LW] : p[k*LW +: LW];
            check(rx_q_valid === 1'b1 && rx_q_data[k*LW +: LW] === e, "R9",
                  64'(rx_q_data[k*LW +: LW]), 64'(e));
         end
      end
      rx_valid = 1'b0;
      @(negedge clk);
      p = rx_q_data;
      rx_data = rnd(); rx_inv = 4'hF;
      @(negedge clk);
      check(rx_q_valid === 1'b0 && rx_q_data === p, "R10", 64'(rx_q_data), 64'(p));
   endtask

   // write and read in the same cycle: previous encoded beat looped back
   task automatic t_loop();
      logic [BW-1:0] prev_plain;
      prev_plain = 32'hA5A5_5A5A;
      send(prev_plain, "R2");
      for (int i = 0; i < 10; i++) begin
         logic [BW-1:0] nxt;
         nxt = rnd();
         rx_valid = 1'b1;
         rx_data  = tx_q_data;
         rx_inv   = tx_q_inv;
         send(nxt, "R11");
         check(rx_q_valid === 1'b1 && rx_q_data === prev_plain, "R9",
               64'(rx_q_data), 64'(prev_plain));
         prev_plain = nxt;
      end
      rx_valid = 1'b0;
      idle(1);
   endtask

   task automatic t_mid_reset();
      send(32'h0F0F_0F0F, "R8");
      idle(1);
      t_reset();
      // from all-zero reference, 5 ones must invert on every lane
      send(32'h1F1F_1F1F, "R8");
      check(tx_q_data === 32'hE0E0_E0E0 && tx_q_inv === 4'hF, "R8",
            {28'd0, tx_q_inv, tx_q_data}, {28'd0, 4'hF, 32'hE0E0_E0E0});
      idle(1);
   endtask

   initial begin
      fork
         begin
            model_reset();
            t_reset();
            t_threshold();
            t_persist();
            t_stream();
            t_decode();
            t_loop();
            t_mid_reset();
         end
         begin
            repeat (50000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule